// File: doc/BRIEF.md
# Column-to-Row Transposition Buffer

This block sits between two identical matrix-multiply stages of a two-dimensional transform pipeline. The first stage produces a block of 64 signed 16-bit intermediate values, one per clock, eight at a time per column. The second stage needs the same matrix eight at a time per row. The buffer stores the incoming block and plays it back in transposed order, so that one stage design can serve both directions of the transform.

Storage is split into two banks. While one bank is filled with a new block, the other is drained, so blocks can arrive back to back at one sample per clock with no stall. A block is opened by a start pulse. The mode word sampled with that pulse travels alongside the data and comes out with the first output sample, so the downstream stage can pick the matching coefficient set. Blocks may also be separated by idle gaps of any length. During a gap the output is marked invalid and its data is held at zero.

Top module: `xpose_buf`

## Requirements
- R1: While reset is asserted and right after it, out_valid and out_start are 0 and out_data is 0.
- R2: When in_start is 1 and no block is being filled, the sample on in_data in that cycle is sample 0 of a new block. The next 63 cycles supply samples 1 to 63. in_mode is captured in that same cycle.
- R3: During the 63 cycles that follow an accepted start, in_start and in_mode are ignored. Neither restarts the block nor changes its mode.
- R4: Output sample j of a block (j = 0..63) equals input sample (j mod 8)*8 + (j div 8) of that block, so each group of eight outputs is one row of the column-ordered input.
- R5: Output sample 0 appears 64 cycles after input sample 0 was sampled. out_start is 1 only in that cycle.
- R6: Each block yields exactly 64 consecutive cycles with out_valid = 1. out_start is 0 for samples 1 to 63.
- R7: Blocks whose starts are 64 cycles apart yield one unbroken run of valid output with no idle cycle between blocks.
- R8: In every cycle with out_valid = 0, out_data is 0 and out_start is 0.
- R9: out_mode equals the mode captured for the block being output, and it stays constant over all 64 of its samples.
- R10: The bank being read is never the bank being written in the same cycle, so filling a block never corrupts the block being drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_start | input | 1 | Marks sample 0 of a new block |
| in_mode | input | 3 | Block mode, sampled with the start |
| in_data | input | 16 | Signed intermediate sample, column order |
| out_valid | output | 1 | Output sample is valid |
| out_start | output | 1 | Marks output sample 0 of a block |
| out_mode | output | 3 | Mode of the block being output |
| out_data | output | 16 | Signed sample, row order; zero when invalid |

## Verification
The bound checker watches the output framing in every cycle. It checks that runs of valid output last exactly 64 cycles and start only on a marked sample, that gap cycles carry zero data, that the mode is held across a run, that reading starts the cycle after the last write, that starts are ignored during a fill, and that the read and write banks never coincide. Sample order, mode capture and exact latency are properties of data values across many cycles. Only the bench's reference transpose can show these, by comparing every output cycle in single, gapped, back-to-back, noisy-start and extreme-value block scenarios.

// File: rtl/xpose_pkg.sv
package xpose_pkg;

  // Storage slot for column-ordered input sample idx so that a linear
  // read returns the matrix row by row.
  function automatic int unsigned col_to_row_addr(int unsigned idx, int unsigned dim);
    return (idx % dim) * dim + (idx / dim);
  endfunction

  // Index of the input sample that output position pos must carry.
  function automatic int unsigned row_source_index(int unsigned pos, int unsigned dim);
    return (pos % dim) * dim + (pos / dim);
  endfunction

endpackage

// File: rtl/xpose_wr_ctrl.sv
module xpose_wr_ctrl #(
  parameter int DIM    = 8,
  parameter int MODE_W = 3,
  localparam int N     = DIM * DIM,
  localparam int AW    = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_start,
  input  logic [MODE_W-1:0] in_mode,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic              wr_bank,
  output logic              wr_last,
  output logic              filling,
  output logic [MODE_W-1:0] blk_mode
);
  logic [AW-1:0] wr_cnt;
  logic          accept;

  assign accept  = in_start && !filling;
  assign wr_en   = accept || filling;
  assign wr_last = filling && (wr_cnt == AW'(N - 1));
  assign wr_addr = AW'(xpose_pkg::col_to_row_addr(32'(wr_cnt), DIM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cnt   <= '0;
      filling  <= 1'b0;
      wr_bank  <= 1'b0;
      blk_mode <= '0;
    end else if (accept) begin
      wr_cnt   <= AW'(1);
      filling  <= 1'b1;
      blk_mode <= in_mode;
    end else if (filling) begin
      if (wr_last) begin
        wr_cnt  <= '0;
        filling <= 1'b0;
        wr_bank <= ~wr_bank;
      end else begin
        wr_cnt <= wr_cnt + AW'(1);
      end
    end
  end
endmodule

// File: rtl/xpose_rd_ctrl.sv
module xpose_rd_ctrl #(
  parameter int DIM    = 8,
  parameter int MODE_W = 3,
  localparam int N     = DIM * DIM,
  localparam int AW    = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_last,
  input  logic              wr_bank,
  input  logic [MODE_W-1:0] blk_mode,
  output logic              rd_active,
  output logic [AW-1:0]     rd_addr,
  output logic              rd_bank,
  output logic              rd_first,
  output logic [MODE_W-1:0] rd_mode
);
  assign rd_first = rd_active && (rd_addr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_active <= 1'b0;
      rd_addr   <= '0;
      rd_bank   <= 1'b0;
      rd_mode   <= '0;
    end else if (wr_last) begin
      rd_active <= 1'b1;
      rd_addr   <= '0;
      rd_bank   <= wr_bank;
      rd_mode   <= blk_mode;
    end else if (rd_active) begin
      if (rd_addr == AW'(N - 1)) begin
        rd_active <= 1'b0;
        rd_addr   <= '0;
      end else begin
        rd_addr <= rd_addr + AW'(1);
      end
    end
  end
endmodule

// File: rtl/xpose_bank_mem.sv
module xpose_bank_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int BANKS = 2
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_bank,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] bank_q [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] arr [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(b))) arr[wr_addr] <= wr_data;
    end
    assign bank_q[b] = arr[rd_addr];
  end

  assign rd_data = bank_q[rd_bank];
endmodule

// File: rtl/xpose_buf.sv
module xpose_buf #(
  parameter int DIM    = 8,
  parameter int DATA_W = 16,
  parameter int MODE_W = 3,
  localparam int N     = DIM * DIM,
  localparam int AW    = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_start,
  input  logic [MODE_W-1:0] in_mode,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_start,
  output logic [MODE_W-1:0] out_mode,
  output logic [DATA_W-1:0] out_data
);
  // Named internal events, visible to the bound checker.
  logic              wr_fire;
  logic              wr_last;
  logic              wr_bank;
  logic              filling;
  logic [AW-1:0]     wr_addr;
  logic [MODE_W-1:0] blk_mode;
  logic              rd_active;
  logic              rd_first;
  logic              rd_bank;
  logic [AW-1:0]     rd_addr;
  logic [MODE_W-1:0] rd_mode;
  logic [DATA_W-1:0] rd_data;

  xpose_wr_ctrl #(.DIM(DIM), .MODE_W(MODE_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_mode(in_mode),
    .wr_en(wr_fire), .wr_addr(wr_addr), .wr_bank(wr_bank),
    .wr_last(wr_last), .filling(filling), .blk_mode(blk_mode)
  );

  xpose_rd_ctrl #(.DIM(DIM), .MODE_W(MODE_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .wr_last(wr_last), .wr_bank(wr_bank),
    .blk_mode(blk_mode), .rd_active(rd_active), .rd_addr(rd_addr),
    .rd_bank(rd_bank), .rd_first(rd_first), .rd_mode(rd_mode)
  );

  xpose_bank_mem #(.DATA_W(DATA_W), .DEPTH(N)) u_mem (
    .clk(clk), .wr_en(wr_fire), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data(in_data), .rd_bank(rd_bank), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_start <= 1'b0;
      out_mode  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= rd_active;
      out_start <= rd_first;
      out_data  <= rd_active ? rd_data : '0;
      if (rd_first) out_mode <= rd_mode;
    end
  end
endmodule

// File: rtl/xpose_buf_chk.sv
module xpose_buf_chk #(
  parameter int DIM    = 8,
  parameter int DATA_W = 16,
  parameter int MODE_W = 3,
  localparam int N     = DIM * DIM,
  localparam int VW    = $clog2(N) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_start,
  input logic              filling,
  input logic              wr_fire,
  input logic              wr_last,
  input logic              wr_bank,
  input logic              rd_active,
  input logic              rd_first,
  input logic              rd_bank,
  input logic              out_valid,
  input logic              out_start,
  input logic [MODE_W-1:0] out_mode,
  input logic [DATA_W-1:0] out_data
);
  // Length of the current (or just ended) valid output run.
  logic [VW-1:0] vcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         vcnt <= '0;
    else if (!out_valid) vcnt <= '0;
    else if (out_start)  vcnt <= VW'(1);
    else                 vcnt <= vcnt + VW'(1);
  end

  AST_START_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> out_valid);  // R6
  AST_RUN_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_start) |-> (vcnt != '0 && vcnt < VW'(N)));  // R6
  AST_RUN_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && vcnt != '0) |-> (vcnt == VW'(N)));  // R6
  AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0 && !out_start));  // R8
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_start) |-> $stable(out_mode));  // R9
  AST_READ_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_last |=> rd_first);  // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (filling && in_start && !wr_last) |=> filling);  // R3
  AST_BANKS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active && wr_fire) |-> (rd_bank != wr_bank));  // R10
endmodule

bind xpose_buf xpose_buf_chk #(.DIM(DIM), .DATA_W(DATA_W), .MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_start(in_start), .filling(filling),
  .wr_fire(wr_fire), .wr_last(wr_last), .wr_bank(wr_bank),
  .rd_active(rd_active), .rd_first(rd_first), .rd_bank(rd_bank),
  .out_valid(out_valid), .out_start(out_start), .out_mode(out_mode),
  .out_data(out_data)
);

// File: tb/xpose_buf_test.sv
`timescale 1ns/1ps
module xpose_buf_test;
  localparam int DIM = 8;
  localparam int N   = DIM * DIM;
  localparam int DW  = 16;
  localparam int MW  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_start = 1'b0;
  logic [MW-1:0] in_mode = '0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid, out_start;
  logic [MW-1:0] out_mode;
  logic [DW-1:0] out_data;

  always #4 clk = ~clk;  // 125 MHz

  xpose_buf uut (
    .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_mode(in_mode),
    .in_data(in_data), .out_valid(out_valid), .out_start(out_start),
    .out_mode(out_mode), .out_data(out_data)
  );

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  string scen = "R4";

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s cycle=%0d actual=%0d expected=%0d", req, what, cyc, act, exp);
    end
  endtask

  // Behavioural reference: collect a block, schedule its transpose.
  bit            m_fill = 0;
  int            m_cnt = 0, m_c0 = 0;
  logic [MW-1:0] m_mode = '0;
  string         m_tag = "";
  logic [DW-1:0] m_buf [N];
  logic [DW-1:0] e_data [int];
  logic [MW-1:0] e_mode [int];
  bit            e_first [int];
  string         e_tag [int];

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_fill = 0;
    end else begin
      if (!m_fill && in_start) begin
        m_fill = 1; m_cnt = 0; m_c0 = cyc; m_mode = in_mode; m_tag = scen;
      end
      if (m_fill) begin
        m_buf[m_cnt] = in_data;
        m_cnt++;
        if (m_cnt == N) begin
          m_fill = 0;
          for (int j = 0; j < N; j++) begin
            e_data[m_c0 + N + j]  = m_buf[(j % DIM) * DIM + j / DIM];
            e_mode[m_c0 + N + j]  = m_mode;
            e_first[m_c0 + N + j] = (j == 0);
            e_tag[m_c0 + N + j]   = m_tag;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (e_data.exists(cyc)) begin
        chk(out_valid == 1'b1, "R2", "out_valid", int'(out_valid), 1);
        chk(out_data == e_data[cyc], e_tag[cyc], "out_data order",
            int'(out_data), int'(e_data[cyc]));
        chk(out_start == e_first[cyc], e_first[cyc] ? "R5" : "R6", "out_start",
            int'(out_start), int'(e_first[cyc]));
        chk(out_mode == e_mode[cyc], "R9", "out_mode", int'(out_mode), int'(e_mode[cyc]));
        e_data.delete(cyc); e_mode.delete(cyc); e_first.delete(cyc); e_tag.delete(cyc);
      end else begin
        chk(out_valid == 1'b0, "R8", "gap out_valid", int'(out_valid), 0);
        chk(out_data == '0, "R8", "gap out_data", int'(out_data), 0);
        chk(out_start == 1'b0, "R8", "gap out_start", int'(out_start), 0);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog all actual=%0d expected<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // kind 0 ramp, 1 random, 2 extremes; noisy raises in_start mid-block (R3)
  task automatic send_block(logic [MW-1:0] mode, int kind, bit noisy);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      in_start = (i == 0) || (noisy && (i % 5 == 2));
      in_mode  = (i == 0) ? mode : MW'($urandom);
      case (kind)
        0:       in_data = DW'(i * 3 - 50);
        1:       in_data = DW'($urandom);
        default: in_data = (i % 3 == 0) ? 16'h7FFF : (i % 3 == 1) ? 16'h8000 : DW'(i);
      endcase
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_start = 1'b0;
      in_mode  = MW'($urandom);
      in_data  = DW'($urandom);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "reset out_valid", int'(out_valid), 0);
    chk(out_start == 1'b0, "R1", "reset out_start", int'(out_start), 0);
    chk(out_data == '0, "R1", "reset out_data", int'(out_data), 0);
    rst_n = 1'b1;
    idle(5);
    scen = "R4"; send_block(3'd3, 0, 0);   // single block, then long gap (R8)
    idle(100);
    scen = "R7";                           // back to back
    send_block(3'd1, 1, 0);
    send_block(3'd5, 1, 0);
    send_block(3'd7, 1, 0);
    idle(10);
    scen = "R3"; send_block(3'd2, 1, 1);   // start and mode noise mid-block
    idle(1);
    scen = "R10"; send_block(3'd4, 1, 1);  // fill next bank while draining
    send_block(3'd0, 2, 0);
    idle(200);
    chk(e_data.num() == 0, "R5", "pending outputs", e_data.num(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule